// File: doc/BRIEF.md
# Strobe-Driven Shared-Bus Register Section

This block is the register section of a small processor datapath, one bit column repeated across the word width. Eight word registers (X, Y, A, L, Q, Z, B, G) never load from a multiplexer. Every register whose active-low read strobe is 0 puts its contents on one common read bus, which is an OR of all active sources. The write bus carries the inverted value, so it rests at all ones and a 1 on the bus appears as a 0. An outside source, such as memory or an I/O path, can also drive bits onto the read bus. Any register whose active-low write strobe is 0 takes that value.

A transfer takes two clock cycles, and the strobes stay the same for both. In the first cycle the timing phase input is high. Each selected destination sees a clear pulse, built inside the block from its write strobe and the phase, and goes to zero. In the second cycle the phase is low. Each bit where the write bus carries a 1 is set. A register whose write strobe is held high does not change, and that includes the source.

The block also gives two views that need no storage. C is the bitwise complement of B. U is the sum of X and Y with the carry-out dropped. Registers reset synchronously to zero.

Top module: `strobe_bus_regs`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) makes all eight registers zero at that edge.
- R2: The read bus is the OR of `ext_rd_i` and the contents of every register whose `rd_n` bit is 0. The strobe bit index and the slice of `regs_o` both follow the order X=0, Y=1, A=2, L=3, Q=4, Z=5, B=6, G=7, and register k sits at `regs_o[k*W +: W]`. With no read strobe active and `ext_rd_i` zero, the read bus is zero.
- R3: The write bus is at all times the bitwise inverse of the read bus.
- R4: A register whose `wr_n` bit is 0 while `phase_clr_i` is 1 is zero after that edge.
- R5: A register whose `wr_n` bit is 0 while `phase_clr_i` is 0 becomes its old value OR the read bus. A clear cycle followed by a set cycle with the same strobes therefore loads the bus value.
- R6: A register whose `wr_n` bit is 1 keeps its value at every edge. This includes the source of a transfer.
- R7: When two or more sources are read in the same transfer, the destination receives the bitwise OR of those sources.
- R8: When several write strobes are active in one transfer, every selected destination receives the same bus value.
- R9: `c_o` always equals the bitwise complement of B.
- R10: `u_o` always equals (X + Y) modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 8 | Active-low read strobes, one per register |
| wr_n | input | 8 | Active-low write strobes, one per register |
| phase_clr_i | input | 1 | Timing phase; high marks the clear half of a transfer |
| ext_rd_i | input | W | External contribution ORed onto the read bus |
| regs_o | output | 8*W | Register contents, register k at bits k*W +: W |
| rbus_o | output | W | Read bus value |
| wbus_o | output | W | Write bus value (inverted read bus) |
| c_o | output | W | Complement of B |
| u_o | output | W | Adder output X + Y |

## Verification
The external bus input loads distinct patterns into registers. The tests then run single-source moves, two-source transfers and fan-out to three destinations. Single-source moves show whether the destination really copies the source while the source itself is left alone. Two-source transfers show whether the read bus is a true OR rather than a pick of one source. Fan-out shows whether every selected register is written. Set-only writes with no clear phase, a clear phase with no set phase, a register that is both source and destination, a cycle with no strobes, an adder overflow, and a reset in the middle of the run tell apart the clear and set halves of a transfer, the idle level of the bus, and the dropped carry.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int NREG = 8;
  localparam int IDX_X = 0;
  localparam int IDX_Y = 1;
  localparam int IDX_A = 2;
  localparam int IDX_L = 3;
  localparam int IDX_Q = 4;
  localparam int IDX_Z = 5;
  localparam int IDX_B = 6;
  localparam int IDX_G = 7;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_SET   = 2'd2
  } reg_act_e;
endpackage

// File: rtl/sbr_action_gen.sv
// Turns write strobes and the timing phase into per-register clear and set actions.
module sbr_action_gen
  import sbr_pkg::*;
(
  input  logic [NREG-1:0] wr_n,
  input  logic            phase_clr_i,
  output logic [NREG-1:0] clr_o,
  output logic [NREG-1:0] set_o
);
  reg_act_e act [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_act
    always_comb begin
      if (wr_n[k])          act[k] = ACT_IDLE;
      else if (phase_clr_i) act[k] = ACT_CLEAR;
      else                  act[k] = ACT_SET;
    end
    assign clr_o[k] = (act[k] == ACT_CLEAR);
    assign set_o[k] = (act[k] == ACT_SET);
  end
endmodule

// File: rtl/sbr_bus.sv
// Wired-OR read bus fan-in and inverted write bus fan-out.
module sbr_bus
  import sbr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NREG*W-1:0] regs_i,
  input  logic [NREG-1:0]   rd_n,
  input  logic [W-1:0]      ext_i,
  output logic [W-1:0]      rbus_o,
  output logic [W-1:0]      wbus_o
);
  logic [W-1:0] acc [NREG+1];

  assign acc[0] = ext_i;
  for (genvar k = 0; k < NREG; k++) begin : g_fanin
    logic [W-1:0] content;
    assign content    = regs_i[k*W +: W] & {W{~rd_n[k]}};
    assign acc[k + 1] = acc[k] | content;
  end

  assign rbus_o = acc[NREG];
  assign wbus_o = ~acc[NREG];
endmodule

// File: rtl/sbr_reg_cell.sv
// One word register: clear forces zero, set ORs in bits carried as 0 on the write bus.
module sbr_reg_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic [W-1:0] wbus_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_bits;
  assign set_bits = ~wbus_i & {W{set_i}};

  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= q_o | set_bits;
  end
endmodule

// File: rtl/sbr_adder.sv
module sbr_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i]       = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end
endmodule

// File: rtl/strobe_bus_regs.sv
module strobe_bus_regs
  import sbr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   rd_n,
  input  logic [NREG-1:0]   wr_n,
  input  logic              phase_clr_i,
  input  logic [W-1:0]      ext_rd_i,
  output logic [NREG*W-1:0] regs_o,
  output logic [W-1:0]      rbus_o,
  output logic [W-1:0]      wbus_o,
  output logic [W-1:0]      c_o,
  output logic [W-1:0]      u_o
);
  localparam int TOTW = NREG * W;

  logic [NREG-1:0] clr;
  logic [NREG-1:0] set;
  logic [TOTW-1:0] regs;
  logic [W-1:0]    rbus;
  logic [W-1:0]    wbus;

  sbr_action_gen u_act (
    .wr_n        (wr_n),
    .phase_clr_i (phase_clr_i),
    .clr_o       (clr),
    .set_o       (set)
  );

  sbr_bus #(.W(W)) u_bus (
    .regs_i (regs),
    .rd_n   (rd_n),
    .ext_i  (ext_rd_i),
    .rbus_o (rbus),
    .wbus_o (wbus)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    sbr_reg_cell #(.W(W)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr[k]),
      .set_i  (set[k]),
      .wbus_i (wbus),
      .q_o    (regs[k*W +: W])
    );
  end

  sbr_adder #(.W(W)) u_add (
    .a_i (regs[IDX_X*W +: W]),
    .b_i (regs[IDX_Y*W +: W]),
    .s_o (u_o)
  );

  assign c_o    = ~regs[IDX_B*W +: W];
  assign regs_o = regs;
  assign rbus_o = rbus;
  assign wbus_o = wbus;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
  import sbr_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NREG-1:0]   rd_n,
  input logic [NREG-1:0]   wr_n,
  input logic              phase_clr_i,
  input logic [W-1:0]      ext_rd_i,
  input logic [NREG*W-1:0] regs_o,
  input logic [W-1:0]      rbus_o,
  input logic [W-1:0]      wbus_o,
  input logic [W-1:0]      c_o,
  input logic [W-1:0]      u_o
);
  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> regs_o == '0);

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (&rd_n && ext_rd_i == '0) |-> rbus_o == '0);

  assert_wbus_inverse_R3: assert property (@(posedge clk) disable iff (rst)
    wbus_o == ~rbus_o);

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (!wr_n[k] && phase_clr_i) |=> regs_o[k*W +: W] == '0);
    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
      (!wr_n[k] && !phase_clr_i) |=>
        regs_o[k*W +: W] == ($past(regs_o[k*W +: W]) | $past(rbus_o)));
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      wr_n[k] |=> $stable(regs_o[k*W +: W]));
  end

  assert_complement_R9: assert property (@(posedge clk) disable iff (rst)
    c_o == ~regs_o[IDX_B*W +: W]);

  assert_sum_R10: assert property (@(posedge clk) disable iff (rst)
    u_o == W'(regs_o[IDX_X*W +: W] + regs_o[IDX_Y*W +: W]));
endmodule

bind strobe_bus_regs sbr_checker #(.W(W)) u_sbr_checker (
  .clk         (clk),
  .rst         (rst),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .phase_clr_i (phase_clr_i),
  .ext_rd_i    (ext_rd_i),
  .regs_o      (regs_o),
  .rbus_o      (rbus_o),
  .wbus_o      (wbus_o),
  .c_o         (c_o),
  .u_o         (u_o)
);

// File: tb/strobe_bus_regs_bench.sv
`timescale 1ns/1ps
module strobe_bus_regs_bench;
  localparam int W = 16;
  localparam int N = 8;
  localparam int XI = 0, YI = 1, AI = 2, LI = 3, QI = 4, ZI = 5, BI = 6, GI = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   rd_n = '1;
  logic [N-1:0]   wr_n = '1;
  logic           phase_clr_i = 1'b0;
  logic [W-1:0]   ext_rd_i = '0;
  logic [N*W-1:0] regs_o;
  logic [W-1:0]   rbus_o, wbus_o, c_o, u_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  logic [W-1:0] model [N];

  always #2 clk = ~clk;

  strobe_bus_regs #(.W(W)) u_strobe_bus_regs (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .phase_clr_i(phase_clr_i),
    .ext_rd_i(ext_rd_i), .regs_o(regs_o), .rbus_o(rbus_o), .wbus_o(wbus_o),
    .c_o(c_o), .u_o(u_o)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] model_bus(input logic [N-1:0] r, input logic [W-1:0] e);
    logic [W-1:0] b = e;
    for (int k = 0; k < N; k++) if (!r[k]) b |= model[k];
    return b;
  endfunction

  task automatic check_state(input string tag);
    for (int k = 0; k < N; k++) chk({tag, " reg R5/R6"}, regs_o[k*W +: W], model[k]);
    chk("R9 complement", c_o, ~model[BI]);
    chk("R10 sum", u_o, model[XI] + model[YI]);
  endtask

  // One clock cycle: drive at negedge, check buses, step model at the edge, check registers.
  task automatic step(input logic r, input logic [N-1:0] rd, input logic [N-1:0] wr,
                      input logic ph, input logic [W-1:0] ext);
    logic [W-1:0] bus;
    @(negedge clk);
    rst = r; rd_n = rd; wr_n = wr; phase_clr_i = ph; ext_rd_i = ext;
    #1;
    bus = model_bus(rd, ext);
    if (!r) begin
      chk("R2 read bus", rbus_o, bus);
      chk("R3 write bus", wbus_o, ~bus);
    end
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      if (r) model[k] = '0;
      else if (!wr[k]) model[k] = ph ? '0 : (model[k] | bus);
    end
    #1;
    check_state(r ? "R1" : "cyc");
  endtask

  function automatic logic [N-1:0] sel(input int a, input int b = -1, input int c = -1);
    logic [N-1:0] m = '1;
    m[a] = 1'b0;
    if (b >= 0) m[b] = 1'b0;
    if (c >= 0) m[c] = 1'b0;
    return m;
  endfunction

  task automatic xfer(input logic [N-1:0] rd, input logic [N-1:0] wr, input logic [W-1:0] ext);
    step(0, rd, wr, 1'b1, ext);
    step(0, rd, wr, 1'b0, ext);
  endtask

  initial begin
    for (int k = 0; k < N; k++) model[k] = 'x;
    step(1, '1, '1, 0, '0);
    step(1, '1, '1, 0, '0);
    for (int k = 0; k < N; k++) chk("R1 reset", regs_o[k*W +: W], '0);

    xfer('1, sel(XI), 16'h1234);               // R2 external load into X
    xfer('1, sel(YI), 16'hF00F);
    chk("R10 X+Y", u_o, 16'h0243);
    xfer(sel(XI), sel(AI), '0);                // single move, source held (R6)
    chk("R5 A gets X", regs_o[AI*W +: W], 16'h1234);
    chk("R6 X kept", regs_o[XI*W +: W], 16'h1234);
    xfer(sel(XI, YI), sel(LI), '0);            // R7 OR of two sources
    chk("R7 L = X|Y", regs_o[LI*W +: W], 16'hF23F);
    xfer(sel(LI), sel(QI, ZI, BI), '0);        // R8 fan-out
    chk("R8 Q", regs_o[QI*W +: W], 16'hF23F);
    chk("R8 Z", regs_o[ZI*W +: W], 16'hF23F);
    chk("R8 B", regs_o[BI*W +: W], 16'hF23F);
    chk("R9 C", c_o, 16'h0DC0);
    step(0, '1, sel(AI), 0, 16'h0C00);         // R5 set without clear ORs in
    chk("R5 set-only", regs_o[AI*W +: W], 16'h1E34);
    step(0, sel(GI), sel(GI), 1, 16'h5555);    // R4 clear with no set phase
    chk("R4 clear", regs_o[GI*W +: W], 16'h0000);
    step(0, '1, '1, 0, '0);                    // R2 idle bus
    chk("R2 idle", rbus_o, '0);
    chk("R3 idle", wbus_o, 16'hFFFF);
    xfer(sel(AI), sel(AI), '0);                // self transfer: cleared first
    chk("R4 self", regs_o[AI*W +: W], 16'h0000);
    xfer('1, sel(XI), 16'hFFFF);
    xfer('1, sel(YI), 16'h0002);
    chk("R10 overflow", u_o, 16'h0001);
    xfer(sel(XI, QI), sel(GI), 16'h8000);
    step(1, '1, '1, 0, '0);                    // R1 mid-run reset
    for (int k = 0; k < N; k++) chk("R1 mid reset", regs_o[k*W +: W], '0);
    step(0, '1, '1, 0, '0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got=%0d expected=<20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule